// File: doc/BRIEF.md
# Register File with Low Shadow Bank

This block holds the general-purpose integer registers of a core: 32 entries of 32 bits, read through two combinational ports and written through one synchronous port. Next to the main array sits a small shadow bank of four registers. While the alternate-bank input is high, register indices 0 to 3 are steered to the shadow bank instead of the main entries. A short exception handler, such as a translation-miss refill routine, can then use four scratch registers without first spilling the interrupted program's low registers. The alternate-bank input is raised by the machine-state logic on entry to such a handler and dropped again on return from interrupt; that logic lives outside this block.

While the alternate bank is selected, indices 4 to 31 are not defined for use. The block gives this a fixed meaning: reads of those indices return zero and writes to them are discarded. The alternate-bank input is taken per access, so a read and a write in the same cycle both follow its present level. There is no bypass: a read of the entry being written in the same cycle returns the value held before the write.

Top module: `gpr_shadow_rf`

## Requirements
- R1: After reset, every main entry and every shadow entry reads as zero, and asserting the reset later clears both banks again.
- R2: With the alternate-bank input low, a write to any index 0 to 31 is returned by both read ports for that index from the next cycle on; index 0 is an ordinary storage register.
- R3: With the alternate-bank input high, reads and writes of indices 0 to 3 go to shadow entry 0 to 3 of the same number.
- R4: Writes made while the alternate-bank input is high leave main entries 0 to 3 unchanged.
- R5: With the alternate-bank input high, a read of any index 4 to 31 returns zero on that port.
- R6: With the alternate-bank input high, a write to any index 4 to 31 is discarded and no main entry changes.
- R7: Writes made while the alternate-bank input is low leave all four shadow entries unchanged.
- R8: A read of the index being written in the same cycle returns the value held before that write; the new value appears from the next cycle.
- R9: The alternate-bank input is taken per cycle: a write and a read in the same cycle both follow its level in that cycle, and a change of level takes effect for reads in the cycle it occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears both banks |
| alt_bank_i | input | 1 | High selects the shadow bank for indices 0 to 3 |
| rd_a_addr_i | input | 5 | Read port A index |
| rd_a_data_o | output | 32 | Read port A data, combinational |
| rd_b_addr_i | input | 5 | Read port B index |
| rd_b_data_o | output | 32 | Read port B data, combinational |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write index |
| wr_data_i | input | 32 | Write data |

## Verification
The assertions assume that the alternate-bank input, write enable, write index and read indices are driven to known levels and stay stable around each rising clock edge, because the hold and landing properties compare sampled state across one edge. The bench drives every input shortly after the falling edge and reads the combinational outputs a nanosecond later, well before the next rising edge, so the input values seen at each edge are settled and the value checked is the one held before that edge's write. It also drives accesses to indices 4 to 31 while the shadow bank is selected, deliberately and with defined expected results, so the zero-read and dropped-write properties are exercised rather than avoided.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_DEPTH    = 32;
  localparam int RF_WIDTH    = 32;
  localparam int RF_SHADOW   = 4;
  localparam int RF_RD_PORTS = 2;

  // Where an access at a given index lands
  typedef enum logic [1:0] {
    TGT_MAIN   = 2'd0,
    TGT_SHADOW = 2'd1,
    TGT_NONE   = 2'd2
  } rf_tgt_e;
endpackage

// File: rtl/rf_route.sv
module rf_route
  import rf_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int SHADOW_N = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              alt_i,
  output rf_tgt_e           tgt_o
);
  localparam logic [ADDR_W-1:0] LOW_END = ADDR_W'(SHADOW_N);

  logic is_low;
  assign is_low = (addr_i < LOW_END);

  always_comb begin
    if (!alt_i)      tgt_o = TGT_MAIN;
    else if (is_low) tgt_o = TGT_SHADOW;
    else             tgt_o = TGT_NONE;
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  parameter int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [AW-1:0]                waddr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DEPTH-1:0][DATA_W-1:0] mem_o
);
  logic [DEPTH-1:0][DATA_W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign mem_o = mem_q;

  AST_BANK_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i)); // R2

  AST_BANK_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q)); // R8
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int DATA_W   = 32,
  parameter int SHADOW_N = 4,
  parameter int ADDR_W   = $clog2(DEPTH),
  parameter int SH_W     = (SHADOW_N > 1) ? $clog2(SHADOW_N) : 1
) (
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic                            alt_i,
  input  logic [DEPTH-1:0][DATA_W-1:0]    main_i,
  input  logic [SHADOW_N-1:0][DATA_W-1:0] shadow_i,
  output logic [DATA_W-1:0]               data_o
);
  rf_tgt_e tgt;

  rf_route #(.ADDR_W(ADDR_W), .SHADOW_N(SHADOW_N)) u_route (
    .addr_i (addr_i),
    .alt_i  (alt_i),
    .tgt_o  (tgt)
  );

  always_comb begin
    unique case (tgt)
      TGT_MAIN:   data_o = main_i[addr_i];
      TGT_SHADOW: data_o = shadow_i[addr_i[SH_W-1:0]];
      default:    data_o = '0; // undefined region reads as zero
    endcase
  end
endmodule

// File: rtl/gpr_shadow_rf.sv
module gpr_shadow_rf
  import rf_pkg::*;
#(
  parameter int NUM_REGS = RF_DEPTH,
  parameter int DATA_W   = RF_WIDTH,
  parameter int SHADOW_N = RF_SHADOW,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alt_bank_i,
  input  logic [ADDR_W-1:0] rd_a_addr_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [ADDR_W-1:0] rd_b_addr_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int SH_W  = (SHADOW_N > 1) ? $clog2(SHADOW_N) : 1;
  localparam int NPORT = RF_RD_PORTS;

  logic [NUM_REGS-1:0][DATA_W-1:0] main_q;
  logic [SHADOW_N-1:0][DATA_W-1:0] shadow_q;
  rf_tgt_e wr_tgt;
  logic    main_we, shadow_we;

  rf_route #(.ADDR_W(ADDR_W), .SHADOW_N(SHADOW_N)) u_wr_route (
    .addr_i (wr_addr_i),
    .alt_i  (alt_bank_i),
    .tgt_o  (wr_tgt)
  );

  assign main_we   = wr_en_i && (wr_tgt == TGT_MAIN);
  assign shadow_we = wr_en_i && (wr_tgt == TGT_SHADOW);

  rf_bank #(.DEPTH(NUM_REGS), .DATA_W(DATA_W), .AW(ADDR_W)) u_main (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (main_we),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_data_i),
    .mem_o   (main_q)
  );

  rf_bank #(.DEPTH(SHADOW_N), .DATA_W(DATA_W), .AW(SH_W)) u_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (shadow_we),
    .waddr_i (wr_addr_i[SH_W-1:0]),
    .wdata_i (wr_data_i),
    .mem_o   (shadow_q)
  );

  logic [NPORT-1:0][ADDR_W-1:0] rd_addr;
  logic [NPORT-1:0][DATA_W-1:0] rd_data;

  assign rd_addr[0] = rd_a_addr_i;
  assign rd_addr[1] = rd_b_addr_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    rf_read_port #(
      .DEPTH(NUM_REGS), .DATA_W(DATA_W), .SHADOW_N(SHADOW_N),
      .ADDR_W(ADDR_W), .SH_W(SH_W)
    ) u_port (
      .addr_i   (rd_addr[p]),
      .alt_i    (alt_bank_i),
      .main_i   (main_q),
      .shadow_i (shadow_q),
      .data_o   (rd_data[p])
    );
  end

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];

  localparam logic [ADDR_W-1:0] LOW_END = ADDR_W'(SHADOW_N);

  AST_MAIN_LOW_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_bank_i |=> $stable(main_q[SHADOW_N-1:0])); // R4

  AST_MAIN_ALL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_bank_i |=> $stable(main_q)); // R6

  AST_SHADOW_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alt_bank_i |=> $stable(shadow_q)); // R7

  AST_HIGH_READ_ZERO_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alt_bank_i && rd_a_addr_i >= LOW_END) |-> rd_a_data_o == '0); // R5

  AST_HIGH_READ_ZERO_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alt_bank_i && rd_b_addr_i >= LOW_END) |-> rd_b_data_o == '0); // R5

  AST_SHADOW_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && alt_bank_i && wr_addr_i < LOW_END)
      |=> shadow_q[$past(wr_addr_i[SH_W-1:0])] == $past(wr_data_i)); // R3

  AST_SHADOW_READ_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alt_bank_i && rd_a_addr_i < LOW_END)
      |-> rd_a_data_o == shadow_q[rd_a_addr_i[SH_W-1:0]]); // R9
endmodule

// File: tb/gpr_shadow_rf_test.sv
module gpr_shadow_rf_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        alt_bank_i = 1'b0;
  logic [4:0]  rd_a_addr_i = '0;
  logic [31:0] rd_a_data_o;
  logic [4:0]  rd_b_addr_i = '0;
  logic [31:0] rd_b_data_o;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  gpr_shadow_rf uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .alt_bank_i  (alt_bank_i),
    .rd_a_addr_i (rd_a_addr_i),
    .rd_a_data_o (rd_a_data_o),
    .rd_b_addr_i (rd_b_addr_i),
    .rd_b_data_o (rd_b_data_o),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i)
  );

  typedef struct packed {
    logic        alt;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic [4:0]  ra;
    logic [4:0]  rb;
    logic [31:0] ea;
    logic [31:0] eb;
  } vec_t;

  // Reads are checked before the edge that performs the row's write.
  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 5'd0,  32'h1111_0000, 5'd0,  5'd5,  32'h0,          32'h0},          // R2 R8
    '{1'b0, 1'b1, 5'd5,  32'h5555_5555, 5'd0,  5'd5,  32'h1111_0000, 32'h0},          // R2 R8
    '{1'b0, 1'b1, 5'd31, 32'hFFFF_0031, 5'd5,  5'd31, 32'h5555_5555, 32'h0},          // R2
    '{1'b0, 1'b1, 5'd3,  32'h3333_3333, 5'd31, 5'd3,  32'hFFFF_0031, 32'h0},          // R2
    '{1'b1, 1'b1, 5'd0,  32'hCAFE_0000, 5'd0,  5'd3,  32'h0,          32'h0},          // R3
    '{1'b1, 1'b1, 5'd3,  32'hBEEF_0003, 5'd0,  5'd5,  32'hCAFE_0000, 32'h0},          // R3 R5
    '{1'b1, 1'b1, 5'd5,  32'hDEAD_0005, 5'd3,  5'd31, 32'hBEEF_0003, 32'h0},          // R5 R6
    '{1'b0, 1'b0, 5'd0,  32'h0,          5'd0,  5'd3,  32'h1111_0000, 32'h3333_3333}, // R4
    '{1'b0, 1'b0, 5'd0,  32'h0,          5'd5,  5'd31, 32'h5555_5555, 32'hFFFF_0031}, // R6
    '{1'b0, 1'b1, 5'd0,  32'h0000_AAAA, 5'd5,  5'd0,  32'h5555_5555, 32'h1111_0000}, // R8
    '{1'b1, 1'b0, 5'd0,  32'h0,          5'd0,  5'd3,  32'hCAFE_0000, 32'hBEEF_0003}, // R7
    '{1'b0, 1'b0, 5'd0,  32'h0,          5'd0,  5'd0,  32'h0000_AAAA, 32'h0000_AAAA}  // R2
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic alt, input logic we, input logic [4:0] wa,
                       input logic [31:0] wd, input logic [4:0] ra, input logic [4:0] rb);
    alt_bank_i  = alt;
    wr_en_i     = we;
    wr_addr_i   = wa;
    wr_data_i   = wd;
    rd_a_addr_i = ra;
    rd_b_addr_i = rb;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: reset state of both banks
    for (int i = 0; i < 32; i++) begin
      drive(1'b0, 1'b0, 5'd0, 32'h0, 5'(i), 5'(31 - i));
      check($sformatf("R1 main idx %0d port A", i), rd_a_data_o, 32'h0);
    end
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, 1'b0, 5'd0, 32'h0, 5'(i), 5'(3 - i));
      check($sformatf("R1 shadow idx %0d port B", 3 - i), rd_b_data_o, 32'h0);
    end
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      drive(VECS[v].alt, VECS[v].we, VECS[v].wa, VECS[v].wd, VECS[v].ra, VECS[v].rb);
      check($sformatf("R2-table row %0d port A", v), rd_a_data_o, VECS[v].ea);
      check($sformatf("R8-table row %0d port B", v), rd_b_data_o, VECS[v].eb);
      @(negedge clk);
    end

    // R9: per-cycle bank select; write and read in one cycle follow the level
    drive(1'b1, 1'b1, 5'd1, 32'h9999_0001, 5'd1, 5'd0);
    check("R9 same-cycle shadow read old", rd_a_data_o, 32'h0);
    check("R9 shadow idx0 port B", rd_b_data_o, 32'hCAFE_0000);
    @(negedge clk);
    drive(1'b1, 1'b0, 5'd0, 32'h0, 5'd1, 5'd1);
    check("R3 shadow idx1 after write", rd_a_data_o, 32'h9999_0001);
    drive(1'b0, 1'b0, 5'd0, 32'h0, 5'd1, 5'd1);
    check("R9 level drop same cycle main idx1", rd_b_data_o, 32'h0);
    @(negedge clk);

    // R5: every high index reads zero with shadow selected
    for (int i = 4; i < 32; i++) begin
      drive(1'b1, 1'b0, 5'd0, 32'h0, 5'(i), 5'(i));
      if (i == 5 || i == 31) check($sformatf("R5 high idx %0d", i), rd_a_data_o, 32'h0);
    end
    @(negedge clk);

    // R1: reset mid-run clears both banks
    drive(1'b0, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
    rst_ni = 1'b0;
    #1;
    check("R1 main idx0 after re-reset", rd_a_data_o, 32'h0);
    drive(1'b1, 1'b0, 5'd0, 32'h0, 5'd0, 5'd1);
    check("R1 shadow idx0 after re-reset", rd_a_data_o, 32'h0);
    check("R1 shadow idx1 after re-reset", rd_b_data_o, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule